// File: doc/BRIEF.md
# Dual-Channel PIO Access Command Engine

This block is the function layer of a single-wire slave. It becomes active only after the addressing layer has selected the device. It takes the bits that the bit-level receiver recovers, one strobe per time slot, and assembles them into a command byte. Two commands are recognised.

- **Read (F5h):** the engine streams status bytes for two open-drain output channels, one after another, until the bus is reset.
- **Write (5Ah):** the engine runs a loop. In each pass it receives a data byte and then that byte inverted. If the pair is consistent, it loads the two output latches. It then sends back a fixed confirmation byte (AAh) and a freshly sampled status byte, and waits for the next data byte.

Pin levels are sampled at the strobe of the last bit of the byte that comes before each status byte. The latch outputs drive the external pulldown transistors. A latch value of 1 means the transistor is off.

Top module: `pio_access_engine`

## Requirements
- R1: After a bus reset, when the command byte 8'hF5 is received (bits arrive LSB first), the engine transmits status bytes back to back, with no limit, until the next bus reset.
- R2: A status byte is sent LSB first. Bit 0 is the channel A pin level, bit 1 the channel A latch, bit 2 the channel B pin level, bit 3 the channel B latch. Bits 7..4 are the inverse of bits 3..0.
- R3: Both pin levels are captured together at the slot strobe of bit 7 of the byte that precedes each status byte. A pin change after that strobe does not appear until the following status byte.
- R4: In the write command (8'h5A), bit 0 of the data byte goes to the channel A latch and bit 1 goes to the channel B latch. The latch takes the bit's true value, where 1 means the pulldown is off.
- R5: The latches load only at the strobe of bit 7 of the second byte, and only when that byte equals the bitwise inverse of the data byte. They do not change at any other time.
- R6: After a valid pair, the engine sends 8'hAA and then a status byte. That status byte is sampled at bit 7 of 8'hAA and reflects the new latch values. The engine then accepts another data byte pair.
- R7: After rst_n, both latches are 1 and the engine is not transmitting.
- R8: A bus reset ends any command and returns the engine to waiting for a command byte. The latch values are kept.
- R9: After a non-inverse second byte, or after an unrecognised command byte, the latches keep their values and the engine transmits nothing until a bus reset.
- R10: While sel is low, slot strobes are ignored. The engine state and the latches do not change.
- R11: tx_en is high only while the engine sends a byte. When tx_en is low, tx_bit is 1 (the line is released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_rst | input | 1 | One-cycle pulse when a bus reset is detected |
| sel | input | 1 | High while the addressing layer has selected this device |
| slot_stb | input | 1 | One-cycle strobe per time slot |
| slot_bit | input | 1 | Line level sampled in the current slot |
| pin_lvl | input | NUM_CH | Pin levels; bit 0 is channel A |
| tx_bit | output | 1 | Bit to present in the next read slot (1 = release) |
| tx_en | output | 1 | High while a byte is being sent |
| pio_latch | output | NUM_CH | Output latches; 1 = pulldown off |

## Verification
The assertions watch the latches and the transmitter on every cycle:
- the latches never move without a selected slot strobe;
- a latch change is always followed directly by the confirmation transmission;
- a bus reset always silences the transmitter.

The bench's scenarios are needed for the things a single-cycle property cannot capture: the exact bit content of the status and confirmation bytes, the point at which a pin change first shows up, the refusal of mismatched pairs, and the endless repetition of both loops.

// File: rtl/pio_acc_pkg.sv
package pio_acc_pkg;
   typedef enum logic [2:0] {
      ST_CMD  = 3'd0,
      ST_RD   = 3'd1,
      ST_WDAT = 3'd2,
      ST_WINV = 3'd3,
      ST_CONF = 3'd4,
      ST_STAT = 3'd5,
      ST_DEAD = 3'd6
   } eng_st_e;

   localparam logic [7:0] CODE_READ  = 8'hF5;
   localparam logic [7:0] CODE_WRITE = 8'h5A;
   localparam logic [7:0] CODE_CONF  = 8'hAA;
endpackage

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("pio_pin_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '{default: '1};
         else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/pio_status_fmt.sv
module pio_status_fmt #(
   parameter int NUM_CH = 2,
   parameter int BYTE_W = 8
) (
   input  logic [NUM_CH-1:0] pins,
   input  logic [NUM_CH-1:0] latches,
   output logic [BYTE_W-1:0] status
);
   localparam int LOW_W = 2 * NUM_CH;

   if (BYTE_W != 2 * LOW_W) begin : g_bad
      $error("pio_status_fmt: BYTE_W must be 4*NUM_CH");
   end

   logic [LOW_W-1:0] low;
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign low[2*c]   = pins[c];
      assign low[2*c+1] = latches[c];
   end

   assign status = {~low, low};
endmodule

// File: rtl/pio_latch_bank.sv
module pio_latch_bank #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NUM_CH-1:0] value,
   output logic [NUM_CH-1:0] q
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q[c] <= 1'b1;
         else if (load) q[c] <= value[c];
      end
   end
endmodule

// File: rtl/pio_access_engine.sv
module pio_access_engine
   import pio_acc_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              sel,
   input  logic              slot_stb,
   input  logic              slot_bit,
   input  logic [NUM_CH-1:0] pin_lvl,
   output logic              tx_bit,
   output logic              tx_en,
   output logic [NUM_CH-1:0] pio_latch
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

   if (NUM_CH != 2 || BYTE_W != 8) begin : g_bad
      $error("pio_access_engine: status layout needs NUM_CH=2, BYTE_W=8");
   end

   eng_st_e           st;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] data_q, tx_sh, rx_byte, status;
   logic [NUM_CH-1:0] pins_s;
   logic              act, last_bit, pair_ok, ld;

   pio_pin_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_lvl), .q(pins_s));

   pio_status_fmt #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_fmt (
      .pins(pins_s), .latches(pio_latch), .status(status));

   assign act      = slot_stb && sel && !bus_rst;
   assign last_bit = (bit_cnt == LAST_IDX);
   assign rx_byte  = {slot_bit, rx_sh};
   assign pair_ok  = (rx_byte == ~data_q);
   assign ld       = act && (st == ST_WINV) && last_bit && pair_ok;

   pio_latch_bank #(.NUM_CH(NUM_CH)) u_lat (
      .clk(clk), .rst_n(rst_n), .load(ld),
      .value(data_q[NUM_CH-1:0]), .q(pio_latch));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_CMD;
         bit_cnt <= '0;
         rx_sh   <= '0;
         data_q  <= '1;
         tx_sh   <= '1;
      end else if (bus_rst) begin
         st      <= ST_CMD;
         bit_cnt <= '0;
         tx_sh   <= '1;
      end else if (act) begin
         bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
         rx_sh   <= rx_byte[BYTE_W-1:1];
         tx_sh   <= {1'b1, tx_sh[BYTE_W-1:1]};
         if (last_bit) begin
            case (st)
               ST_CMD: begin
                  if (rx_byte == CODE_READ) begin
                     st    <= ST_RD;
                     tx_sh <= status;
                  end else if (rx_byte == CODE_WRITE) begin
                     st <= ST_WDAT;
                  end else begin
                     st <= ST_DEAD;
                  end
               end
               ST_RD:   tx_sh <= status;
               ST_WDAT: begin
                  data_q <= rx_byte;
                  st     <= ST_WINV;
               end
               ST_WINV: begin
                  if (pair_ok) begin
                     st    <= ST_CONF;
                     tx_sh <= CODE_CONF;
                  end else begin
                     st <= ST_DEAD;
                  end
               end
               ST_CONF: begin
                  st    <= ST_STAT;
                  tx_sh <= status;
               end
               ST_STAT: st <= ST_WDAT;
               default: st <= st;
            endcase
         end
      end
   end

   assign tx_en  = (st == ST_RD) || (st == ST_CONF) || (st == ST_STAT);
   assign tx_bit = tx_en ? tx_sh[0] : 1'b1;
endmodule

// File: rtl/pio_access_checker.sv
module pio_access_checker #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rst,
   input logic              sel,
   input logic              slot_stb,
   input logic              tx_en,
   input logic [NUM_CH-1:0] pio_latch
);
   AST_LATCH_HOLD_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(pio_latch));                               // R10
   AST_LATCH_ONLY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_stb |=> $stable(pio_latch));                          // R5
   AST_BUS_RST_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !tx_en);                                        // R8
   AST_UPDATE_THEN_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pio_latch) |-> tx_en);                             // R6
endmodule

bind pio_access_engine pio_access_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .sel(sel),
   .slot_stb(slot_stb), .tx_en(tx_en), .pio_latch(pio_latch));

// File: tb/sim_pio_access_engine.sv
`timescale 1ns/1ps
module sim_pio_access_engine;
   logic clk = 0, rst_n = 0, bus_rst = 0, sel = 0, slot_stb = 0, slot_bit = 1;
   logic [1:0] pins = 2'b11;
   logic tx_bit, tx_en;
   logic [1:0] pio_latch;
   int checks = 0, failures = 0;
   bit running = 0, finished = 0;

   always #5 clk = ~clk;

   pio_access_engine u0 (.clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .sel(sel),
      .slot_stb(slot_stb), .slot_bit(slot_bit), .pin_lvl(pins),
      .tx_bit(tx_bit), .tx_en(tx_en), .pio_latch(pio_latch));

   // behavioural reference
   int   m_mode = 0;      // 0 cmd,1 read,2 data,3 inverse,4 confirm,5 status,6 dead
   int   m_cnt = 0;
   int   m_rx = 0, m_wd = 0;
   logic [1:0] m_lat = 2'b11;
   bit   txq[$];

   function automatic int stat_byte();
      int lo = {m_lat[1], pins[1], m_lat[0], pins[0]};
      return ((~lo & 15) << 4) | lo;
   endfunction

   function automatic void push_byte(int b);
      for (int i = 0; i < 8; i++) txq.push_back(b[i]);
   endfunction

   function automatic bit m_txing();
      return m_mode == 1 || m_mode == 4 || m_mode == 5;
   endfunction

   function automatic void model_slot(bit b);
      if (!sel) return;
      if (m_txing() && txq.size() > 0) void'(txq.pop_front());
      m_rx = (m_rx >> 1) | (int'(b) << 7);
      m_cnt++;
      if (m_cnt < 8) return;
      m_cnt = 0;
      case (m_mode)
         0: if (m_rx == 'hF5) begin m_mode = 1; push_byte(stat_byte()); end
            else if (m_rx == 'h5A) m_mode = 2;
            else m_mode = 6;
         1: push_byte(stat_byte());
         2: begin m_wd = m_rx; m_mode = 3; end
         3: if (m_rx == (~m_wd & 'hFF)) begin
               m_lat = m_wd[1:0]; m_mode = 4; push_byte('hAA);
            end else m_mode = 6;
         4: begin push_byte(stat_byte()); m_mode = 5; end
         5: m_mode = 2;
         default: ;
      endcase
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) if (running) begin
      check(pio_latch == m_lat, "R5 latch", pio_latch, m_lat);
      check(tx_en == m_txing(), "R11 tx_en", tx_en, m_txing());
      check(tx_bit == ((m_txing() && txq.size() > 0) ? txq[0] : 1'b1),
            "R2 tx_bit", tx_bit, (m_txing() && txq.size() > 0) ? txq[0] : 1'b1);
   end

   task automatic do_slot(bit b);
      @(negedge clk); slot_stb = 1; slot_bit = b;
      @(posedge clk); #1; slot_stb = 0; slot_bit = 1; model_slot(b);
      @(negedge clk);
   endtask

   task automatic send_byte(int v);
      for (int i = 0; i < 8; i++) do_slot(v[i]);
   endtask

   task automatic read_byte(output int v);
      v = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); v[i] = tx_bit;
         do_slot(1'b1);
      end
   endtask

   task automatic do_bus_rst();
      @(negedge clk); bus_rst = 1;
      @(posedge clk); #1; bus_rst = 0;
      m_mode = 0; m_cnt = 0; m_rx = 0; txq.delete();
      @(negedge clk);
   endtask

   task automatic set_pins(logic [1:0] p);
      @(negedge clk); pins = p;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R7 reset state
      check(pio_latch == 2'b11, "R7 latch after reset", pio_latch, 3);
      check(tx_en == 0 && tx_bit == 1, "R7 idle after reset", {tx_en, tx_bit}, 1);
      running = 1;

      // R1 R2 R3: read stream, pin change mid-stream
      sel = 1; set_pins(2'b10);
      do_bus_rst();
      send_byte('hF5);
      set_pins(2'b01);
      read_byte(v); check(v == 'h1E, "R3 first status uses old pins", v, 'h1E);
      read_byte(v); check(v == 'h4B, "R2 status layout", v, 'h4B);
      read_byte(v); check(v == 'h4B, "R1 endless stream", v, 'h4B);
      check(tx_en == 1, "R1 still sending", tx_en, 1);
      do_bus_rst();
      check(tx_en == 0, "R8 reset ends read", tx_en, 0);

      // R4 R5 R6 write loop
      set_pins(2'b11);
      send_byte('h5A);
      send_byte('hFE);
      for (int i = 0; i < 7; i++) do_slot(i == 0);
      check(pio_latch == 2'b11, "R5 no load before MSB", pio_latch, 3);
      do_slot(1'b0);
      check(pio_latch == 2'b10, "R4 channel A on", pio_latch, 2);
      read_byte(v); check(v == 'hAA, "R6 confirmation", v, 'hAA);
      read_byte(v); check(v == 'h2D, "R6 status after write", v, 'h2D);
      send_byte('hFD); send_byte('h02);
      check(pio_latch == 2'b01, "R4 channel B on", pio_latch, 1);
      read_byte(v); check(v == 'hAA, "R6 loop confirmation", v, 'hAA);
      read_byte(v);
      send_byte('hFF); send_byte('h00);
      check(pio_latch == 2'b11, "R6 third pass", pio_latch, 3);
      read_byte(v); read_byte(v);

      // R9 mismatched pair
      send_byte('hFC); send_byte('h01);
      check(pio_latch == 2'b11, "R9 mismatch keeps latch", pio_latch, 3);
      read_byte(v); check(v == 'hFF && tx_en == 0, "R9 silent after mismatch", v, 'hFF);
      do_bus_rst();
      check(pio_latch == 2'b11, "R8 latch kept over bus reset", pio_latch, 3);

      // R9 unknown command
      send_byte('h33);
      read_byte(v); check(v == 'hFF, "R9 unknown command silent", v, 'hFF);
      do_bus_rst();

      // R10 unselected
      sel = 0;
      send_byte('h5A); send_byte('hFC); send_byte('h03);
      check(pio_latch == 2'b11, "R10 ignored while unselected", pio_latch, 3);
      check(tx_en == 0, "R10 no transmit while unselected", tx_en, 0);
      sel = 1;
      send_byte('h5A); send_byte('hFC); send_byte('h03);
      check(pio_latch == 2'b00, "R10 selected write applies", pio_latch, 0);
      read_byte(v); check(v == 'hAA, "R6 confirm after select", v, 'hAA);
      do_bus_rst();
      set_pins(2'b00);
      send_byte('hF5);
      read_byte(v); check(v == 'hF0, "R2 all low status", v, 'hF0);

      running = 0;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule